// File: doc/BRIEF.md
# Masked Coincidence Hit Encoder

The block takes two banks of discriminated hit levels, one from each side of a detector, with 152 channels per side by default. Each bank is first gated by its own enable mask. The two masked banks are then combined channel by channel with a logical AND, so a channel counts only when both sides fired together. A capture strobe freezes this coincidence pattern in a register. An encoder then reduces the stored pattern to three values for the trigger path: the lowest channel that is set, a flag that says whether any channel is set, and a count of the set channels that saturates at 15.

A simple word-wide host register bus writes and reads both masks. It also reads back the stored pattern and the encoded result. The pattern is wider than one bus word, so the host reads it in several accesses. Reading the first pattern word takes a snapshot of the pattern and of the encoded result. The later words of the same read sequence come from that snapshot, so a capture that lands in the middle of the sequence cannot mix two events.

The hit inputs are assumed to be synchronous levels that are already qualified for a single cycle.

Top module: `hit_coinc_encoder`

## Requirements
- R1: After reset, every bit of both masks is 1, the stored pattern is all zero, and trig_valid, trig_addr and trig_count are all 0.
- R2: When cap_strobe is sampled high, stored pattern bit i becomes hit_right[i] & hit_left[i] & right_mask[i] & left_mask[i].
- R3: A channel whose bit is cleared in either mask never appears in the stored pattern, whatever the other mask holds.
- R4: When cap_strobe is low, the stored pattern keeps its value whatever the hit inputs do.
- R5: trig_addr is the lowest index of a set pattern bit, and trig_valid is 1 exactly when some pattern bit is set. When the pattern is empty, both are 0.
- R6: trig_count is the number of set pattern bits, saturated at 15.
- R7: The trigger outputs change one clock after the pattern register takes its new value. That is the second rising edge counted from the edge that samples cap_strobe. They then hold until the next capture.
- R8: Mask words sit at addresses 0 to 4 (right side) and 8 to 12 (left side). Bit j of word w controls channel 32*w + j. Bits 24 to 31 of word 4 are not stored and read back as 0.
- R9: Pattern words sit at addresses 16 to 20, with the same bit layout as the masks. A read of address 16 returns the live word 0 and snapshots the whole pattern and the encoded result. Reads of 17 to 20 and of 24 return that snapshot, even if a capture happens after the snapshot.
- R10: The encoded word at address 24 holds trig_addr in bits 7:0, trig_valid in bit 8 and trig_count in bits 12:9. All other bits are 0.
- R11: bus_rdata updates on the clock edge that samples bus_rd. It is 0 after an edge without a read and 0 for an unmapped address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_right | input | 152 | Right-side hit levels |
| hit_left | input | 152 | Left-side hit levels |
| cap_strobe | input | 1 | Captures the coincidence pattern when high |
| bus_wr | input | 1 | Host write enable |
| bus_rd | input | 1 | Host read enable |
| bus_addr | input | 5 | Host word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| trig_valid | output | 1 | Some coincidence channel is set |
| trig_addr | output | 8 | Lowest set coincidence channel |
| trig_count | output | 4 | Set channel count, saturated at 15 |

## Verification
The hardest case to reach from the ports is a capture that lands between the first and a later word of a host read sequence, because the snapshot only shows its value when the live pattern has already moved on. The stimulus reads word 0, then captures a clearly different pattern, then reads word 1 and the encoded word, and expects the old event in both. After that it reads word 0 again and expects the new event. The other hard cases are a lowest set channel at the very top index and a saturated count. These are reached by clearing whole mask words on one side and by driving single-channel and dense hit patterns.

// File: rtl/hce_pkg.sv
package hce_pkg;
  localparam int CH_MAX = 256;
  localparam int BUS_W  = 32;
  localparam int IDX_W  = 8;
  localparam int CNT_W  = 4;

  // lowest set index of a padded pattern
  function automatic logic [IDX_W-1:0] first_set(input logic [CH_MAX-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = CH_MAX - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  // population count saturated at 15
  function automatic logic [CNT_W-1:0] count_sat(input logic [CH_MAX-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < CH_MAX; i++) n += int'(v[i]);
    return (n > 15) ? CNT_W'(15) : CNT_W'(n);
  endfunction

  function automatic logic [BUS_W-1:0] word_of(input logic [CH_MAX-1:0] v, input int w);
    return v[w*BUS_W +: BUS_W];
  endfunction

  function automatic logic [BUS_W-1:0] enc_word(input logic valid,
                                                 input logic [IDX_W-1:0] addr,
                                                 input logic [CNT_W-1:0] cnt);
    logic [BUS_W-1:0] w;
    w = '0;
    w[7:0]  = addr;
    w[8]    = valid;
    w[12:9] = cnt;
    return w;
  endfunction
endpackage

// File: rtl/hce_mask_bank.sv
module hce_mask_bank
  import hce_pkg::*;
#(
  parameter int NCH  = 152,
  parameter int AW   = 5,
  parameter int BASE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [AW-1:0]    waddr,
  input  logic [BUS_W-1:0] wdata,
  output logic [NCH-1:0]   mask
);
  localparam int NW = (NCH + BUS_W - 1) / BUS_W;

  function automatic logic [BUS_W-1:0] keep_bits(input int w);
    logic [BUS_W-1:0] k;
    for (int j = 0; j < BUS_W; j++) k[j] = (w * BUS_W + j) < NCH;
    return k;
  endfunction

  logic [BUS_W-1:0]    words [NW];
  logic [NW*BUS_W-1:0] flat;

  always_ff @(posedge clk) begin
    for (int w = 0; w < NW; w++) begin
      if (!rst_n)
        words[w] <= keep_bits(w);
      else if (wr && waddr == AW'(BASE + w))
        words[w] <= wdata & keep_bits(w);
    end
  end

  always_comb begin
    for (int w = 0; w < NW; w++) flat[w*BUS_W +: BUS_W] = words[w];
  end

  assign mask = flat[NCH-1:0];

  // R8: the mask only moves on a host write
  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask));
endmodule

// File: rtl/hce_capture.sv
module hce_capture #(
  parameter int NCH = 152
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap,
  input  logic [NCH-1:0] hit_r,
  input  logic [NCH-1:0] hit_l,
  input  logic [NCH-1:0] mask_r,
  input  logic [NCH-1:0] mask_l,
  output logic [NCH-1:0] pattern_q
);
  logic [NCH-1:0] side_r;
  logic [NCH-1:0] side_l;
  logic [NCH-1:0] coinc;

  assign side_r = hit_r & mask_r;
  assign side_l = hit_l & mask_l;
  assign coinc  = side_r & side_l;

  always_ff @(posedge clk) begin
    if (!rst_n)   pattern_q <= '0;
    else if (cap) pattern_q <= coinc;
  end

  // R3: a channel disabled on either side never shows up
  p_mask_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (pattern_q & ~($past(mask_r) & $past(mask_l))) == '0);
  // R4: no strobe, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(pattern_q));
endmodule

// File: rtl/hce_encoder.sv
module hce_encoder
  import hce_pkg::*;
#(
  parameter int NCH = 152
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NCH-1:0]   pattern,
  output logic             valid,
  output logic [IDX_W-1:0] addr,
  output logic [CNT_W-1:0] count
);
  logic [CH_MAX-1:0] padded;
  logic              any_set;

  assign padded  = CH_MAX'(pattern);
  assign any_set = |pattern;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      addr  <= '0;
      count <= '0;
    end else if (load) begin
      valid <= any_set;
      addr  <= first_set(padded);
      count <= count_sat(padded);
    end
  end

  // R7: outputs hold between loads
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({valid, addr, count}));
  // R5: valid follows the loaded pattern being non-empty
  p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid == ($past(pattern) != '0));
  // R6: count and valid agree
  p_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid == (count != '0));
endmodule

// File: rtl/hit_coinc_encoder.sv
module hit_coinc_encoder
  import hce_pkg::*;
#(
  parameter int NCH = 152,
  parameter int AW  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   hit_right,
  input  logic [NCH-1:0]   hit_left,
  input  logic             cap_strobe,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             trig_valid,
  output logic [IDX_W-1:0] trig_addr,
  output logic [CNT_W-1:0] trig_count
);
  localparam int NW     = (NCH + BUS_W - 1) / BUS_W;
  localparam int IDX_AW = AW - 2;
  localparam int NSIDE  = 2;

  logic [NCH-1:0]   mask_q [NSIDE];
  logic [NCH-1:0]   pattern_q;
  logic             enc_load;
  logic [1:0]       region;
  logic [IDX_AW-1:0] widx;
  logic             snap_take;
  logic [NCH-1:0]   shadow_pat;
  logic [BUS_W-1:0] shadow_enc;
  logic [BUS_W-1:0] live_enc;

  // one mask bank per side, left bank sits one region above the right
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    hce_mask_bank #(.NCH(NCH), .AW(AW), .BASE(s << IDX_AW)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr),
      .waddr (bus_addr),
      .wdata (bus_wdata),
      .mask  (mask_q[s])
    );
  end

  hce_capture #(.NCH(NCH)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap       (cap_strobe),
    .hit_r     (hit_right),
    .hit_l     (hit_left),
    .mask_r    (mask_q[0]),
    .mask_l    (mask_q[1]),
    .pattern_q (pattern_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) enc_load <= 1'b0;
    else        enc_load <= cap_strobe;
  end

  hce_encoder #(.NCH(NCH)) u_encoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (enc_load),
    .pattern (pattern_q),
    .valid   (trig_valid),
    .addr    (trig_addr),
    .count   (trig_count)
  );

  assign region    = bus_addr[AW-1:AW-2];
  assign widx      = bus_addr[IDX_AW-1:0];
  assign snap_take = bus_rd && region == 2'd2 && widx == '0;
  assign live_enc  = enc_word(trig_valid, trig_addr, trig_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_pat <= '0;
      shadow_enc <= '0;
    end else if (snap_take) begin
      shadow_pat <= pattern_q;
      shadow_enc <= live_enc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !bus_rd) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (region)
        2'd0: if (int'(widx) < NW) bus_rdata <= word_of(CH_MAX'(mask_q[0]), int'(widx));
        2'd1: if (int'(widx) < NW) bus_rdata <= word_of(CH_MAX'(mask_q[1]), int'(widx));
        2'd2: begin
          if (widx == '0)          bus_rdata <= word_of(CH_MAX'(pattern_q), 0);
          else if (int'(widx) < NW) bus_rdata <= word_of(CH_MAX'(shadow_pat), int'(widx));
        end
        default: if (widx == '0) bus_rdata <= shadow_enc;
      endcase
    end
  end

  // R9: the snapshot only moves on a read of the first pattern word
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(shadow_pat) && $stable(shadow_enc));
  // R11: idle bus returns zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0);
endmodule

// File: tb/test_hit_coinc_encoder.sv
module test_hit_coinc_encoder;
  localparam int CLK_P = 10;
  localparam int NCH   = 152;
  localparam int PADW  = 160;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   hit_right = '0;
  logic [NCH-1:0]   hit_left = '0;
  logic             cap_strobe = 1'b0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [4:0]       bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             trig_valid;
  logic [7:0]       trig_addr;
  logic [3:0]       trig_count;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hit_coinc_encoder i_hit_coinc_encoder (
    .clk(clk), .rst_n(rst_n), .hit_right(hit_right), .hit_left(hit_left),
    .cap_strobe(cap_strobe), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_valid(trig_valid),
    .trig_addr(trig_addr), .trig_count(trig_count)
  );

  // bench model
  logic [PADW-1:0] mr, ml, pat;
  logic            e_valid;
  logic [7:0]      e_addr;
  logic [3:0]      e_cnt;

  function automatic logic [7:0] lowest(input logic [PADW-1:0] v);
    int i;
    i = 0;
    while (i < PADW && !v[i]) i++;
    return (i == PADW) ? 8'd0 : 8'(i);
  endfunction

  function automatic logic [3:0] sat_cnt(input logic [PADW-1:0] v);
    int n;
    n = $countones(v);
    return n >= 15 ? 4'd15 : 4'(n);
  endfunction

  function automatic logic [31:0] pack_enc(input logic v, input logic [7:0] a, input logic [3:0] c);
    return {19'd0, c, v, a};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard for bus reads
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        pend_d = 1'b0;

  always @(posedge clk) pend_d <= bus_rd;

  always @(negedge clk) begin
    if (pend_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic bus_read(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 5'd5)      begin mr[a*32 +: 32] = d; mr[PADW-1:NCH] = '0; end
    else if (a >= 5'd8 && a < 5'd13) begin ml[(a-8)*32 +: 32] = d; ml[PADW-1:NCH] = '0; end
  endtask

  task automatic check_trig(input string t);
    check(trig_valid === e_valid, t, 32'(trig_valid), 32'(e_valid));
    check(trig_addr === e_addr, t, 32'(trig_addr), 32'(e_addr));
    check(trig_count === e_cnt, t, 32'(trig_count), 32'(e_cnt));
  endtask

  task automatic capture(input logic [PADW-1:0] r, input logic [PADW-1:0] l);
    @(negedge clk);
    hit_right = r[NCH-1:0]; hit_left = l[NCH-1:0]; cap_strobe = 1'b1;
    @(negedge clk);
    cap_strobe = 1'b0;
    // R7: pattern moved, trigger outputs not yet
    check_trig("R7 before update");
    pat = r & l & mr & ml;
    e_valid = pat != '0;
    e_addr  = lowest(pat);
    e_cnt   = sat_cnt(pat);
    @(negedge clk);
    check_trig("R5/R6/R7 after capture");
  endtask

  task automatic read_pattern(input string t);
    bus_read(5'd16, pat[31:0], t);
    for (int w = 1; w < 5; w++) bus_read(5'(16 + w), pat[w*32 +: 32], t);
    bus_read(5'd24, pack_enc(e_valid, e_addr, e_cnt), "R10 encoded word");
  endtask

  function automatic logic [PADW-1:0] rnd_vec();
    logic [PADW-1:0] v;
    for (int w = 0; w < 5; w++) v[w*32 +: 32] = $urandom;
    v[PADW-1:NCH] = '0;
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [PADW-1:0] r, l, old_pat;
    logic [31:0] old_enc;
    mr = '0; mr[NCH-1:0] = '1;
    ml = mr; pat = '0;
    e_valid = 1'b0; e_addr = '0; e_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_trig("R1 reset trigger");
    check(bus_rdata === 32'd0, "R11 idle rdata", bus_rdata, 32'd0);
    for (int w = 0; w < 5; w++) bus_read(5'(w), mr[w*32 +: 32], "R1 right mask reset");
    bus_read(5'd12, 32'h00ff_ffff, "R1 R8 left mask top word");
    read_pattern("R1 pattern zero");

    // R2 random coincidences with open masks
    for (int k = 0; k < 3; k++) begin
      capture(rnd_vec(), rnd_vec());
      read_pattern("R2 random pattern");
    end

    // R3 R8 masks
    bus_write(5'd1, 32'h0);
    bus_write(5'd10, 32'h0000_ffff);
    bus_write(5'd4, 32'hffff_ffff);
    bus_read(5'd4, 32'h00ff_ffff, "R8 top bits ignored");
    bus_read(5'd1, 32'h0, "R8 right word 1");
    bus_read(5'd10, 32'h0000_ffff, "R8 left word 2");
    r = '0; r[NCH-1:0] = '1;
    capture(r, r);
    read_pattern("R3 masked all-ones");
    check(trig_count === 4'd15, "R6 saturation", 32'(trig_count), 32'd15);

    // R5 sparse and top channel
    r = '0; r[151] = 1'b1; r[140] = 1'b1; r[100] = 1'b1; r[40] = 1'b1;
    l = r; l[90] = 1'b1;
    capture(r, l);
    check(trig_addr === 8'd100, "R5 lowest unmasked", 32'(trig_addr), 32'd100);
    check(trig_count === 4'd3, "R6 small count", 32'(trig_count), 32'd3);
    r = '0; r[151] = 1'b1;
    capture(r, r);
    check(trig_addr === 8'd151, "R5 top channel", 32'(trig_addr), 32'd151);
    capture('0, r);
    check(trig_valid === 1'b0, "R5 empty", 32'(trig_valid), 32'd0);

    // R4 no strobe
    capture(rnd_vec() | 160'h3, rnd_vec() | 160'h3);
    @(negedge clk);
    hit_right = '1; hit_left = '1;
    repeat (4) @(negedge clk);
    check_trig("R4 R7 hold without strobe");
    read_pattern("R4 pattern held");

    // R9 capture between snapshot and later words
    bus_write(5'd1, 32'hffff_ffff);
    bus_write(5'd10, 32'hffff_ffff);
    r = '0; r[35] = 1'b1; r[3] = 1'b1;
    capture(r, r);
    old_pat = pat;
    old_enc = pack_enc(e_valid, e_addr, e_cnt);
    bus_read(5'd16, old_pat[31:0], "R9 snapshot word 0");
    r = '0; r[70] = 1'b1; r[33] = 1'b1;
    capture(r, r);
    bus_read(5'd17, old_pat[63:32], "R9 no tear word 1");
    bus_read(5'd24, old_enc, "R9 no tear encoded");
    read_pattern("R9 fresh snapshot");

    // R11 unmapped
    bus_read(5'd30, 32'd0, "R11 unmapped");
    bus_read(5'd7, 32'd0, "R11 unmapped mask slot");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 reads answered", 32'(exp_q.size()), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule